// File: doc/BRIEF.md
# Two-Level TLB Lookup Unit

This block turns a 32-bit virtual address into a physical address by searching two translation caches in turn. A small fully associative front tier is searched first. A larger fully associative back tier is searched only when the front tier misses. When neither tier holds a match, the block asks an external walker for a translation and waits for it. It installs the returned entry in both tiers and then completes the request. A hit in the back tier is copied into the front tier so that the next access to the same page hits there. Each request carries the address, an 8-bit address-space identifier, a security-world flag, a privilege flag and a write flag.

Every entry holds a page size, a global flag, an address-space identifier, a world tag, a physical page number, a 2-bit permission code, a 4-bit domain number and four memory attributes. An entry matches when all of the following hold:
- its tag equals the address above the page offset;
- it is global or its identifier equals the request's;
- its world tag equals the request's world.

The permission and domain checks run before any address is returned. A failed check produces an abort. A whole-TLB flush and a flush of one identifier each take one cycle, and global entries survive the second.

The controller is a three-state machine:
- S_IDLE accepts requests and searches the front tier.
- S_MAIN searches the back tier.
- S_WALK holds a walk request open.

The transitions are:
- S_IDLE→S_MAIN on a front miss.
- S_MAIN→S_IDLE on a back hit.
- S_MAIN→S_WALK on a back miss.
- S_WALK→S_IDLE when the refill arrives.
- A front hit stays in S_IDLE.

Top module: `tlb_lookup`

## Requirements
- R1: A request accepted in S_IDLE that matches the front tier produces rsp_valid in the cycle after acceptance, with no walk request.
- R2: A request that misses the front tier but matches the back tier produces rsp_valid two cycles after acceptance and copies the entry into the front tier, so that a repeat of it completes in one cycle.
- R3: A request that misses both tiers raises walk_req from the second cycle after acceptance, carrying the request's address, identifier and world, until refill_valid is seen. The response follows one cycle after refill_valid, and the entry is written into both tiers.
- R4: Page size codes are 0=4 KB, 1=64 KB, 2=1 MB and 3=16 MB. The tag compare ignores the address bits below the page size. The returned address takes the entry's page number above the page size and the request's address bits below it.
- R5: A non-global entry matches only a request with the same identifier. A global entry matches any identifier.
- R6: An entry matches only a request from the same world (0 or 1).
- R7: The domain code is dom_mode[2*d+1:2*d] for domain d. Codes 00 and 10 abort. Code 11 allows all access. Code 01 applies the permission code: 00 always aborts, 01 aborts unprivileged access, 10 aborts unprivileged writes, and 11 allows everything. An aborted response has rsp_abort=1, rsp_pa=0 and rsp_attr=0.
- R8: A permitted response returns the entry's attributes on rsp_attr (bit 3 cacheable, bit 2 bufferable, bit 1 device, bit 0 shared).
- R9: A one-cycle flush_all pulse invalidates every entry of both tiers.
- R10: A one-cycle flush_asid_en pulse invalidates the non-global entries whose identifier equals flush_asid. Global entries and entries of other identifiers stay valid.
- R11: Each tier replaces in round-robin order. Five successive installs into the 4-entry front tier evict the first of them.
- R12: req_ready is high in S_IDLE and low in S_MAIN and S_WALK. After reset, req_ready=1, rsp_valid=0 and walk_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Current address-space identifier |
| req_ns | input | 1 | Request world |
| req_priv | input | 1 | Privileged access |
| req_write | input | 1 | Write access |
| dom_mode | input | 32 | Two-bit mode per domain |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate the entries of one identifier |
| flush_asid | input | 8 | Identifier to invalidate |
| walk_req | output | 1 | Translation wanted from the walker |
| walk_va | output | 32 | Address to translate |
| walk_asid | output | 8 | Identifier of the pending request |
| walk_ns | output | 1 | World of the pending request |
| refill_valid | input | 1 | Walker result present |
| refill_ppn | input | 20 | Physical page number |
| refill_size | input | 2 | Page size code |
| refill_global | input | 1 | Entry is global |
| refill_ap | input | 2 | Permission code |
| refill_dom | input | 4 | Domain number |
| refill_attr | input | 4 | Memory attributes |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_pa | output | 32 | Physical address |
| rsp_abort | output | 1 | Access refused |
| rsp_attr | output | 4 | Returned attributes |

## Verification
The translation path is swept over all four page sizes, using offsets that reach each page's last byte. This shows whether the tag mask and the address merge follow the size code. Permission and domain are tried as a full cross of the four permission codes with privilege and write, plus each domain mode. Identifier, global and world patterns are paired with requests that must either walk or hit, which shows whether each match term is enforced. The measured latency (1, 2 or 3 cycles) after flushes and a five-page install sequence shows which tier served each request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int ASID_W  = 8;
    parameter int DOM_W   = 4;
    localparam int NUM_DOM = 1 << DOM_W;
    localparam int VPN_W   = 20;

    typedef enum logic [1:0] {PG_4K, PG_64K, PG_1M, PG_16M} pg_size_t;
    typedef enum logic [1:0] {S_IDLE, S_MAIN, S_WALK} state_t;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        pg_size_t          size;
        logic [ASID_W-1:0] asid;
        logic              glb;
        logic              ns;
        logic [VPN_W-1:0]  ppn;
        logic [1:0]        ap;
        logic [DOM_W-1:0]  dom;
        logic [3:0]        attr;
    } tlb_entry_t;

    // Bits of the page number that take part in the tag compare
    function automatic logic [VPN_W-1:0] vpn_mask(input pg_size_t sz);
        unique case (sz)
            PG_4K:   return 20'hFFFFF;
            PG_64K:  return 20'hFFFF0;
            PG_1M:   return 20'hFFF00;
            default: return 20'hFF000;
        endcase
    endfunction

    function automatic logic entry_match(input tlb_entry_t e,
                                         input logic [VPN_W-1:0] vpn,
                                         input logic [ASID_W-1:0] asid,
                                         input logic ns);
        return e.valid && (((e.vpn ^ vpn) & vpn_mask(e.size)) == '0)
               && (e.glb || (e.asid == asid)) && (e.ns == ns);
    endfunction

    function automatic logic [31:0] phys_addr(input tlb_entry_t e,
                                              input logic [31:0] va);
        logic [VPN_W-1:0] m;
        m = vpn_mask(e.size);
        return {(e.ppn & m) | (va[31:12] & ~m), va[11:0]};
    endfunction
endpackage

// File: rtl/tlb_access_check.sv
module tlb_access_check
    import tlb_pkg::*;
(
    input  logic [1:0]           ap,
    input  logic [DOM_W-1:0]     dom,
    input  logic [2*NUM_DOM-1:0] dom_mode,
    input  logic                 priv,
    input  logic                 write,
    output logic                 allow
);
    logic [1:0] mode;
    logic       ap_ok;

    always_comb begin
        mode = dom_mode[2*dom +: 2];
        unique case (ap)
            2'b00:   ap_ok = 1'b0;
            2'b01:   ap_ok = priv;
            2'b10:   ap_ok = priv || !write;
            default: ap_ok = 1'b1;
        endcase
        unique case (mode)
            2'b11:   allow = 1'b1;
            2'b01:   allow = ap_ok;
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_tier.sv
module tlb_tier
    import tlb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_ns,
    output logic              hit,
    output tlb_entry_t        hit_entry,
    input  logic              wr_en,
    input  tlb_entry_t        wr_entry,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    tlb_entry_t       ents [N];
    logic [N-1:0]     match_vec;
    logic [N-1:0]     valid_vec;
    logic [IDX_W-1:0] ptr;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_ent
            assign match_vec[gi] = entry_match(ents[gi], lk_vpn, lk_asid, lk_ns);
            assign valid_vec[gi] = ents[gi].valid;

            assert_flush_keeps_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (flush_asid_en && !flush_all && !(wr_en && ptr == IDX_W'(gi))
                 && ents[gi].valid && ents[gi].glb) |=> ents[gi].valid);
        end
    endgenerate

    assign hit = |match_vec;

    // Lowest index wins when more than one entry matches
    always_comb begin
        hit_entry = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_entry = ents[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ents[i] <= '0;
            ptr <= '0;
        end else begin
            if (wr_en) begin
                ents[ptr] <= wr_entry;
                ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
            end
            for (int i = 0; i < N; i++) begin
                if (flush_all || (flush_asid_en && !ents[i].glb && ents[i].asid == flush_asid))
                    ents[i].valid <= 1'b0;
            end
        end
    end

    assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));

    assert_rr_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == (($past(ptr) == IDX_W'(N - 1)) ? '0 : $past(ptr) + 1'b1)));
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int MICRO_N = 4,
    parameter int MAIN_N  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [31:0]          req_va,
    input  logic [ASID_W-1:0]    req_asid,
    input  logic                 req_ns,
    input  logic                 req_priv,
    input  logic                 req_write,
    input  logic [2*NUM_DOM-1:0] dom_mode,
    input  logic                 flush_all,
    input  logic                 flush_asid_en,
    input  logic [ASID_W-1:0]    flush_asid,
    output logic                 walk_req,
    output logic [31:0]          walk_va,
    output logic [ASID_W-1:0]    walk_asid,
    output logic                 walk_ns,
    input  logic                 refill_valid,
    input  logic [VPN_W-1:0]     refill_ppn,
    input  logic [1:0]           refill_size,
    input  logic                 refill_global,
    input  logic [1:0]           refill_ap,
    input  logic [DOM_W-1:0]     refill_dom,
    input  logic [3:0]           refill_attr,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_pa,
    output logic                 rsp_abort,
    output logic [3:0]           rsp_attr
);
    state_t            state_q, state_d;
    logic [31:0]       va_q;
    logic [ASID_W-1:0] asid_q;
    logic              ns_q, priv_q, wr_q;

    logic       micro_hit, main_hit;
    tlb_entry_t micro_e, main_e, refill_e, sel_e, micro_wr_e;
    logic       micro_wr, main_wr;
    logic       accept, fire, allow, idle;
    logic [31:0] sel_va;
    logic       sel_priv, sel_wr;

    assign idle     = (state_q == S_IDLE);
    assign accept   = idle && req_valid;
    assign req_ready = idle;

    always_comb begin
        refill_e       = '0;
        refill_e.valid = 1'b1;
        refill_e.vpn   = va_q[31:12];
        refill_e.size  = pg_size_t'(refill_size);
        refill_e.asid  = asid_q;
        refill_e.glb   = refill_global;
        refill_e.ns    = ns_q;
        refill_e.ppn   = refill_ppn;
        refill_e.ap    = refill_ap;
        refill_e.dom   = refill_dom;
        refill_e.attr  = refill_attr;
    end

    tlb_tier #(.N(MICRO_N)) u_micro (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(req_va[31:12]), .lk_asid(req_asid), .lk_ns(req_ns),
        .hit(micro_hit), .hit_entry(micro_e),
        .wr_en(micro_wr), .wr_entry(micro_wr_e),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    tlb_tier #(.N(MAIN_N)) u_main (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(va_q[31:12]), .lk_asid(asid_q), .lk_ns(ns_q),
        .hit(main_hit), .hit_entry(main_e),
        .wr_en(main_wr), .wr_entry(refill_e),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid && !micro_hit) state_d = S_MAIN;
            S_MAIN:  state_d = main_hit ? S_IDLE : S_WALK;
            S_WALK:  if (refill_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            va_q    <= '0;
            asid_q  <= '0;
            ns_q    <= 1'b0;
            priv_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                va_q   <= req_va;
                asid_q <= req_asid;
                ns_q   <= req_ns;
                priv_q <= req_priv;
                wr_q   <= req_write;
            end
        end
    end

    // Tier writes and response selection
    always_comb begin
        micro_wr   = 1'b0;
        main_wr    = 1'b0;
        micro_wr_e = refill_e;
        fire       = 1'b0;
        sel_e      = refill_e;
        unique case (state_q)
            S_IDLE: begin
                fire  = req_valid && micro_hit;
                sel_e = micro_e;
            end
            S_MAIN: begin
                fire       = main_hit;
                sel_e      = main_e;
                micro_wr   = main_hit;
                micro_wr_e = main_e;
            end
            S_WALK: begin
                fire     = refill_valid;
                micro_wr = refill_valid;
                main_wr  = refill_valid;
            end
            default: ;
        endcase
        sel_va   = idle ? req_va    : va_q;
        sel_priv = idle ? req_priv  : priv_q;
        sel_wr   = idle ? req_write : wr_q;
    end

    tlb_access_check u_check (
        .ap(sel_e.ap), .dom(sel_e.dom), .dom_mode(dom_mode),
        .priv(sel_priv), .write(sel_wr), .allow(allow)
    );

    assign walk_req  = (state_q == S_WALK);
    assign walk_va   = va_q;
    assign walk_asid = asid_q;
    assign walk_ns   = ns_q;

    // Registered response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_abort <= 1'b0;
            rsp_attr  <= '0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_abort <= !allow;
                rsp_pa    <= allow ? phys_addr(sel_e, sel_va) : '0;
                rsp_attr  <= allow ? sel_e.attr : '0;
            end
        end
    end

    assert_micro_hit_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && micro_hit) |=> (rsp_valid && !walk_req));

    assert_main_hit_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MAIN && main_hit) |=> (rsp_valid && req_ready));

    assert_walk_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !refill_valid) |=> (walk_req && $stable(walk_va)));

    assert_abort_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort) |-> (rsp_pa == '0 && rsp_attr == '0));

    assert_busy_after_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !micro_hit) |=> !req_ready);
endmodule

// File: tb/tlb_lookup_bench.sv
module tlb_lookup_bench;
    import tlb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic req_valid = 0, req_ready;
    logic [31:0] req_va = 0;
    logic [7:0] req_asid = 0;
    logic req_ns = 0, req_priv = 0, req_write = 0;
    logic [31:0] dom_mode = 32'h5555_5555;
    logic flush_all = 0, flush_asid_en = 0;
    logic [7:0] flush_asid = 0;
    logic walk_req, walk_ns;
    logic [31:0] walk_va;
    logic [7:0] walk_asid;
    logic refill_valid = 0;
    logic [19:0] rf_ppn = 0;
    logic [1:0] rf_size = 0, rf_ap = 2'b11;
    logic rf_glb = 0;
    logic [3:0] rf_dom = 0, rf_attr = 0;
    logic rsp_valid, rsp_abort;
    logic [31:0] rsp_pa;
    logic [3:0] rsp_attr;

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] r_pa;
    logic r_abort;
    logic [3:0] r_attr;

    tlb_lookup u_tlb_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_asid(req_asid), .req_ns(req_ns), .req_priv(req_priv),
        .req_write(req_write), .dom_mode(dom_mode), .flush_all(flush_all),
        .flush_asid_en(flush_asid_en), .flush_asid(flush_asid), .walk_req(walk_req),
        .walk_va(walk_va), .walk_asid(walk_asid), .walk_ns(walk_ns),
        .refill_valid(refill_valid), .refill_ppn(rf_ppn), .refill_size(rf_size),
        .refill_global(rf_glb), .refill_ap(rf_ap), .refill_dom(rf_dom),
        .refill_attr(rf_attr), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_abort(rsp_abort), .rsp_attr(rsp_attr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic ns,
                          input logic pv, input logic wr, output int lat, output bit walked);
        walked = 0;
        @(negedge clk);
        req_va = va; req_asid = asid; req_ns = ns; req_priv = pv; req_write = wr;
        req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        if (!rsp_valid) chk("R12 busy ready", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid && lat < 20) begin
            if (walk_req) begin
                walked = 1;
                chk("R3 walk_va", walk_va, va);
                chk("R3 walk_id", {23'd0, walk_ns, walk_asid}, {23'd0, ns, asid});
                refill_valid = 1;
                @(posedge clk);
                @(negedge clk);
                refill_valid = 0;
            end else begin
                @(posedge clk);
                @(negedge clk);
            end
            lat++;
        end
        chk("R12 response seen", {31'd0, rsp_valid}, 32'd1);
        r_pa = rsp_pa; r_abort = rsp_abort; r_attr = rsp_attr;
    endtask

    // Install a translation by a walk; expects a three-cycle miss path
    task automatic install(input logic [31:0] va, input logic [7:0] asid, input logic ns,
                           input logic [19:0] ppn, input logic [1:0] sz, input logic g,
                           input logic [1:0] ap, input logic [3:0] dm, input logic [3:0] at);
        int lat; bit w;
        rf_ppn = ppn; rf_size = sz; rf_glb = g; rf_ap = ap; rf_dom = dm; rf_attr = at;
        lookup(va, asid, ns, 1'b1, 1'b0, lat, w);
        chk("R3 walk taken", {31'd0, w}, 32'd1);
        chk("R3 walk latency", lat, 3);
    endtask

    task automatic pulse_flush(input bit all, input logic [7:0] id);
        @(negedge clk);
        flush_all = all; flush_asid_en = !all; flush_asid = id;
        @(posedge clk);
        @(negedge clk);
        flush_all = 0; flush_asid_en = 0;
    endtask

    function automatic logic [31:0] exp_pa(input logic [19:0] ppn, input int sz, input logic [31:0] va);
        int bits;
        logic [31:0] m;
        bits = (sz == 0) ? 12 : (sz == 1) ? 16 : (sz == 2) ? 20 : 24;
        m = (32'd1 << bits) - 1;
        return ({ppn, 12'd0} & ~m) | (va & m);
    endfunction

    function automatic bit exp_abort(input int ap, input bit pv, input bit wr);
        return (ap == 0) || (ap == 1 && !pv) || (ap == 2 && !pv && wr);
    endfunction

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        int lat; bit w;
        logic [31:0] offs [8];
        offs = '{32'h0, 32'h123, 32'hFFF, 32'hABCD, 32'hFFFF, 32'h9_8765, 32'hF_FFFF, 32'hFF_FFFF};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R12 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R12 reset walk_req", {31'd0, walk_req}, 32'd0);

        // R3 then R1: miss, then front hit
        install(32'h1234_5678, 8'd5, 1'b0, 20'hABCDE, 2'd0, 1'b0, 2'b11, 4'd0, 4'b1010);
        chk("R4 4K pa", r_pa, 32'hABCD_E678);
        chk("R8 attr", {28'd0, r_attr}, 32'hA);
        lookup(32'h1234_5FFF, 8'd5, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R1 front hit latency", lat, 1);
        chk("R1 front hit pa", r_pa, 32'hABCD_EFFF);

        // R4 sweep over page sizes and offsets
        for (int s = 0; s < 4; s++) begin
            logic [31:0] base;
            logic [19:0] ppn;
            base = 32'h8000_0000 + 32'(s) * 32'h1000_0000;
            ppn = 20'h5A5A5 ^ 20'(s * 20'h11111);
            install(base, 8'd1, 1'b0, ppn, 2'(s), 1'b0, 2'b11, 4'd0, 4'd0);
            for (int k = 0; k < 8; k++) begin
                int bits;
                bits = (s == 0) ? 12 : (s == 1) ? 16 : (s == 2) ? 20 : 24;
                if (offs[k] < (32'd1 << bits)) begin
                    lookup(base + offs[k], 8'd1, 1'b0, 1'b1, 1'b0, lat, w);
                    chk("R4 no walk inside page", {31'd0, w}, 32'd0);
                    chk("R4 sized pa", r_pa, exp_pa(ppn, s, base + offs[k]));
                end
            end
        end

        // R5 identifier and global rule
        install(32'h3000_0000, 8'd5, 1'b0, 20'h11111, 2'd0, 1'b0, 2'b11, 4'd0, 4'd0);
        install(32'h3000_0000, 8'd6, 1'b0, 20'h22222, 2'd0, 1'b0, 2'b11, 4'd0, 4'd0);
        chk("R5 other id own entry", r_pa, 32'h2222_2000);
        lookup(32'h3000_0004, 8'd5, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R5 id 5 keeps own pa", r_pa, 32'h1111_1004);
        install(32'h3100_0000, 8'd5, 1'b0, 20'h33333, 2'd0, 1'b1, 2'b11, 4'd0, 4'd0);
        lookup(32'h3100_0010, 8'd9, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R5 global matches any id", {31'd0, w}, 32'd0);
        chk("R5 global pa", r_pa, 32'h3333_3010);

        // R6 world tag
        install(32'h3000_0000, 8'd5, 1'b1, 20'h44444, 2'd0, 1'b0, 2'b11, 4'd0, 4'd0);
        chk("R6 secure-world entry pa", r_pa, 32'h4444_4000);
        lookup(32'h3000_0008, 8'd5, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R6 other world no walk", {31'd0, w}, 32'd0);
        chk("R6 other world pa", r_pa, 32'h1111_1008);

        // R7 permission cross
        for (int ap = 0; ap < 4; ap++) begin
            install(32'h4000_0000 + 32'(ap) * 32'h1000, 8'd2, 1'b0, 20'h60000 + 20'(ap),
                    2'd0, 1'b0, 2'(ap), 4'd0, 4'b0101);
            for (int p = 0; p < 2; p++) begin
                for (int q = 0; q < 2; q++) begin
                    bit ab;
                    ab = exp_abort(ap, p[0], q[0]);
                    lookup(32'h4000_0040 + 32'(ap) * 32'h1000, 8'd2, 1'b0, p[0], q[0], lat, w);
                    chk("R7 abort by permission", {31'd0, r_abort}, {31'd0, ab});
                    chk("R7 pa zero on abort", r_pa, ab ? 32'd0 : {20'h60000 + 20'(ap), 12'h040});
                    chk("R8 attr or zero", {28'd0, r_attr}, ab ? 32'd0 : 32'h5);
                end
            end
        end

        // R7 domain modes on domain 3
        install(32'h7000_0000, 8'd2, 1'b0, 20'h70000, 2'd0, 1'b0, 2'b11, 4'd3, 4'd3);
        install(32'h7000_1000, 8'd2, 1'b0, 20'h70001, 2'd0, 1'b0, 2'b00, 4'd3, 4'd3);
        for (int dm = 0; dm < 4; dm++) begin
            dom_mode = 32'h5555_5555;
            dom_mode[7:6] = 2'(dm);
            lookup(32'h7000_0000, 8'd2, 1'b0, 1'b0, 1'b1, lat, w);
            chk("R7 domain mode full ap", {31'd0, r_abort}, (dm == 0 || dm == 2) ? 32'd1 : 32'd0);
            lookup(32'h7000_1000, 8'd2, 1'b0, 1'b1, 1'b0, lat, w);
            chk("R7 domain mode no-access ap", {31'd0, r_abort}, (dm == 3) ? 32'd0 : 32'd1);
        end
        dom_mode = 32'h5555_5555;

        // R9 flush all
        lookup(32'h7000_0000, 8'd2, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R9 before flush hit", {31'd0, w}, 32'd0);
        pulse_flush(1'b1, 8'd0);
        install(32'h7000_0000, 8'd2, 1'b0, 20'h70000, 2'd0, 1'b0, 2'b11, 4'd3, 4'd3);
        install(32'h3100_0000, 8'd5, 1'b0, 20'h33333, 2'd0, 1'b1, 2'b11, 4'd0, 4'd0);

        // R10 flush by identifier
        install(32'h5000_0000, 8'd7, 1'b0, 20'h50000, 2'd0, 1'b0, 2'b11, 4'd0, 4'd0);
        install(32'h5100_0000, 8'd7, 1'b0, 20'h51000, 2'd0, 1'b1, 2'b11, 4'd0, 4'd0);
        install(32'h5200_0000, 8'd8, 1'b0, 20'h52000, 2'd0, 1'b0, 2'b11, 4'd0, 4'd0);
        pulse_flush(1'b0, 8'd7);
        lookup(32'h5100_0000, 8'd7, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R10 global survives", {31'd0, w}, 32'd0);
        lookup(32'h5200_0000, 8'd8, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R10 other id survives", {31'd0, w}, 32'd0);
        install(32'h5000_0000, 8'd7, 1'b0, 20'h50000, 2'd0, 1'b0, 2'b11, 4'd0, 4'd0);

        // R11 and R2: five installs, then front/back latency
        pulse_flush(1'b1, 8'd0);
        for (int i = 0; i < 5; i++)
            install(32'h9000_0000 + 32'(i) * 32'h1000, 8'd3, 1'b0, 20'hC0000 + 20'(i),
                    2'd0, 1'b0, 2'b11, 4'd0, 4'd0);
        lookup(32'h9000_4000, 8'd3, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R11 newest in front tier", lat, 1);
        lookup(32'h9000_0000, 8'd3, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R11 oldest evicted, R2 back hit latency", lat, 2);
        chk("R2 back hit pa", r_pa, 32'hC000_0000);
        lookup(32'h9000_0000, 8'd3, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R2 copied to front tier", lat, 1);
        lookup(32'h9000_1000, 8'd3, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R11 next oldest evicted", lat, 2);
        lookup(32'h9000_3000, 8'd3, 1'b0, 1'b1, 1'b0, lat, w);
        chk("R11 untouched stays front", lat, 1);

        finish_run();
    end
endmodule